// File: doc/BRIEF.md
# One-Hot Instruction Length Merger

This block forms the total byte length of a variable-length instruction. It does this by merging one-hot class lines from the earlier decode stages, and it uses no adder. The opcode stage reports which length class the first opcode byte belongs to. When that byte is an escape into a two-byte opcode, it also reports the class of the second opcode byte. A separate operand-descriptor stage reports, for each opcode path, how many extra bytes the addressing form adds. Each length line is an AND-OR of these one-hot products, so exactly one of eleven lines, for lengths 1 to 11, should rise for a legal input.

The two-byte-opcode path is merged first into intermediate length lines. Those lines are then gated by the escape flag and ORed with the one-byte-opcode products. One frequent two-byte class, six bytes with no descriptor, skips the intermediate stage and feeds its final line directly. It therefore resolves at the same depth as a one-byte opcode.

When the active inputs give no length line, or more than one, the block raises a fallback flag for the slow-path handler and reports an all-zero length. Inputs are captured when `in_valid` is high, and the result is registered for one cycle.

Top module: `len_merge_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `out_valid`, `out_fallback` and `out_len` are all zero.
- R2: Inputs sampled with `in_valid` high at a clock edge produce their result, with `out_valid` high, right after that same edge. The result is registered, so there is one cycle of latency.
- R3: `op1_nm` bits 0..5 mean a one-byte opcode of total length 1, 2, 3, 4, 5, 7 with no descriptor. The selected line gives that length directly.
- R4: `op1_wm` bits 0..3 mean base lengths 2, 3, 4, 6 that take a descriptor. `mrm1` bits 0..4 add 0, 1, 2, 4, 5 bytes. The result is the base plus the addition, reaching 11 at most (base 6 with addition 5).
- R5: With `op1_esc` high, `op2_wm` bits 0..1 mean bases 3 and 4 that add the `mrm2` amount (same encoding as `mrm1`). `op2_nm` bits 0..2 mean total lengths 2, 3, 4. All of these counts include the escape byte.
- R6: `op2_nm` bit 3 means a two-byte opcode of total length 6. Gated by `op1_esc`, it drives length line 6 without going through the intermediate merge.
- R7: Without `op1_esc`, the `op2_wm`, `op2_nm` and `mrm2` lines have no effect on the result. Likewise, `mrm1` has no effect unless an `op1_wm` class is active.
- R8: If the active inputs give no length line, or more than one distinct line, `out_fallback` is 1 and `out_len` is all zero.
- R9: `out_len` bit k-1 stands for length k. It never has more than one bit set, and with `out_valid` high and `out_fallback` low it has exactly one.
- R10: After an edge where `in_valid` was low, `out_valid`, `out_fallback` and `out_len` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Class lines are valid this cycle |
| op1_wm | input | 4 | One-byte opcode classes taking a descriptor (bases 2,3,4,6) |
| op1_nm | input | 6 | One-byte opcode classes without descriptor (1,2,3,4,5,7) |
| op1_esc | input | 1 | First byte escapes to a two-byte opcode |
| op2_wm | input | 2 | Second-byte classes taking a descriptor (bases 3,4) |
| op2_nm | input | 4 | Second-byte classes without descriptor (2,3,4,6) |
| mrm1 | input | 5 | Descriptor addition for the one-byte path (0,1,2,4,5) |
| mrm2 | input | 5 | Descriptor addition for the two-byte path (0,1,2,4,5) |
| out_valid | output | 1 | Registered result valid |
| out_fallback | output | 1 | No unique length; hand over to slow path |
| out_len | output | 11 | One-hot length, bit k-1 for length k |

## Verification
The bench builds the block with the package's default class tables: four one-byte descriptor bases, six one-byte direct lengths, two two-byte descriptor bases, four two-byte direct lengths and five descriptor additions. These tables are small enough that every one of the 40 legal class combinations is driven and compared against sums that the bench computes itself. That coverage includes the 11-byte extreme and the bypassed six-byte two-byte form. Directed cases add stray lines on the inactive path to show they are ignored. Further cases give empty or doubly active classes to reach the fallback, and insert idle cycles to show the one-cycle timing.

// File: rtl/len_merge_pkg.sv
// Package: class tables for the length merger.
// Each table lists the byte count that a one-hot class line stands for,
// in bit order of the matching input port. Tables are sorted ascending.
package len_merge_pkg;
    localparam int N_MRM  = 5;
    localparam int N_OP1W = 4;
    localparam int N_OP1N = 6;
    localparam int N_OP2W = 2;
    localparam int N_OP2N = 4;                 // last entry is the bypass class
    localparam int N_OP2M = N_OP2N - 1;        // classes through the first merge

    localparam int MRM_ADD  [N_MRM]  = '{0, 1, 2, 4, 5};
    localparam int OP1W_LEN [N_OP1W] = '{2, 3, 4, 6};
    localparam int OP1N_LEN [N_OP1N] = '{1, 2, 3, 4, 5, 7};
    localparam int OP2W_LEN [N_OP2W] = '{3, 4};
    localparam int OP2N_LEN [N_OP2N] = '{2, 3, 4, 6};

    localparam int FAST_LEN = OP2N_LEN[N_OP2N-1];
    localparam int MAX_LEN  = OP1W_LEN[N_OP1W-1] + MRM_ADD[N_MRM-1];
endpackage

// File: rtl/len_esc_merge.sv
// First merge stage: two-byte-opcode classes combined with their
// descriptor additions into intermediate length lines (bit k-1 = length k).
// Assumes one-hot inputs; the bypass class is not an input here.
module len_esc_merge
    import len_merge_pkg::*;
(
    input  logic [N_OP2W-1:0]  op2_wm,
    input  logic [N_OP2M-1:0]  op2_nm,
    input  logic [N_MRM-1:0]   mrm2,
    output logic [MAX_LEN-1:0] mid
);
    for (genvar k = 1; k <= MAX_LEN; k++) begin : g_mid
        logic hit;
        // OR of every product whose byte count sums to k
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < N_OP2W; i++)
                for (int j = 0; j < N_MRM; j++)
                    if (OP2W_LEN[i] + MRM_ADD[j] == k)
                        hit = hit | (op2_wm[i] & mrm2[j]);
            for (int i = 0; i < N_OP2M; i++)
                if (OP2N_LEN[i] == k)
                    hit = hit | op2_nm[i];
        end
        assign mid[k-1] = hit;
    end
endmodule

// File: rtl/len_final_merge.sv
// Second merge stage: one-byte-opcode products ORed with the escape-gated
// intermediate lines; the bypass class enters its line here directly.
// Assumes mid comes from len_esc_merge.
module len_final_merge
    import len_merge_pkg::*;
(
    input  logic [N_OP1W-1:0]  op1_wm,
    input  logic [N_OP1N-1:0]  op1_nm,
    input  logic               op1_esc,
    input  logic [N_MRM-1:0]   mrm1,
    input  logic [MAX_LEN-1:0] mid,
    input  logic               fast_cls,
    output logic [MAX_LEN-1:0] lines
);
    for (genvar k = 1; k <= MAX_LEN; k++) begin : g_line
        logic hit;
        // OR of one-byte products, escape path and bypass for length k
        always_comb begin
            hit = op1_esc & mid[k-1];
            for (int i = 0; i < N_OP1W; i++)
                for (int j = 0; j < N_MRM; j++)
                    if (OP1W_LEN[i] + MRM_ADD[j] == k)
                        hit = hit | (op1_wm[i] & mrm1[j]);
            for (int i = 0; i < N_OP1N; i++)
                if (OP1N_LEN[i] == k)
                    hit = hit | op1_nm[i];
            if (FAST_LEN == k)
                hit = hit | (op1_esc & fast_cls);
        end
        assign lines[k-1] = hit;
    end
endmodule

// File: rtl/len_onehot_guard.sv
// Checks that exactly one length line is active; otherwise flags
// fallback and clears the vector. Purely combinational.
module len_onehot_guard
    import len_merge_pkg::*;
(
    input  logic [MAX_LEN-1:0] lines,
    output logic [MAX_LEN-1:0] len,
    output logic               fallback
);
    logic single;

    // single is true when lines is non-zero with one bit set
    always_comb begin
        single   = (lines != '0) && ((lines & (lines - 1'b1)) == '0);
        fallback = !single;
        len      = single ? lines : '0;
    end
endmodule

// File: rtl/len_merge_top.sv
// Top of the one-hot length merger: two merge stages, a one-hot guard
// and one output register stage. Synchronous active-low reset.
// Assumes class inputs are one-hot per group when legal.
module len_merge_top
    import len_merge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [N_OP1W-1:0]  op1_wm,
    input  logic [N_OP1N-1:0]  op1_nm,
    input  logic               op1_esc,
    input  logic [N_OP2W-1:0]  op2_wm,
    input  logic [N_OP2N-1:0]  op2_nm,
    input  logic [N_MRM-1:0]   mrm1,
    input  logic [N_MRM-1:0]   mrm2,
    output logic               out_valid,
    output logic               out_fallback,
    output logic [MAX_LEN-1:0] out_len
);
    logic [MAX_LEN-1:0] mid;
    logic [MAX_LEN-1:0] lines;
    logic [MAX_LEN-1:0] len_c;
    logic               fb_c;

    len_esc_merge u_esc (
        .op2_wm (op2_wm),
        .op2_nm (op2_nm[N_OP2M-1:0]),
        .mrm2   (mrm2),
        .mid    (mid)
    );

    len_final_merge u_fin (
        .op1_wm   (op1_wm),
        .op1_nm   (op1_nm),
        .op1_esc  (op1_esc),
        .mrm1     (mrm1),
        .mid      (mid),
        .fast_cls (op2_nm[N_OP2N-1]),
        .lines    (lines)
    );

    len_onehot_guard u_grd (
        .lines    (lines),
        .len      (len_c),
        .fallback (fb_c)
    );

    // Output register: capture result on in_valid, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_fallback <= 1'b0;
            out_len      <= '0;
        end else begin
            out_valid    <= in_valid;
            out_fallback <= in_valid & fb_c;
            out_len      <= in_valid ? len_c : '0;
        end
    end
endmodule

// File: rtl/len_merge_checks.sv
// Checker for len_merge_top: output encoding, timing and bypass rules.
module len_merge_checks
    import len_merge_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [N_OP1W-1:0]  op1_wm,
    input logic [N_OP1N-1:0]  op1_nm,
    input logic               op1_esc,
    input logic [N_OP2W-1:0]  op2_wm,
    input logic [N_OP2N-1:0]  op2_nm,
    input logic               out_valid,
    input logic               out_fallback,
    input logic [MAX_LEN-1:0] out_len
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_fallback && out_len == '0));

    assert_len_onehot0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_len));

    assert_len_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fallback) |-> $countones(out_len) == 1);

    assert_fallback_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fallback |-> (out_len == '0 && out_valid));

    assert_bypass_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op1_esc && op2_nm[N_OP2N-1] && op1_wm == '0 && op1_nm == '0
         && op2_wm == '0 && op2_nm[N_OP2N-2:0] == '0)
        |=> out_len[FAST_LEN-1]);
endmodule

bind len_merge_top len_merge_checks u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op1_wm       (op1_wm),
    .op1_nm       (op1_nm),
    .op1_esc      (op1_esc),
    .op2_wm       (op2_wm),
    .op2_nm       (op2_nm),
    .out_valid    (out_valid),
    .out_fallback (out_fallback),
    .out_len      (out_len)
);

// File: tb/test_len_merge_top.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its own results.
module test_len_merge_top;
    localparam int ML = len_merge_pkg::MAX_LEN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    op1_wm = '0;
    logic [5:0]    op1_nm = '0;
    logic          op1_esc = 1'b0;
    logic [1:0]    op2_wm = '0;
    logic [3:0]    op2_nm = '0;
    logic [4:0]    mrm1 = '0;
    logic [4:0]    mrm2 = '0;
    logic          out_valid;
    logic          out_fallback;
    logic [ML-1:0] out_len;

    int checks = 0;
    int failures = 0;

    // Bench-side byte counts, taken from the requirement text
    int add_v [5] = '{0, 1, 2, 4, 5};
    int w1_v  [4] = '{2, 3, 4, 6};
    int n1_v  [6] = '{1, 2, 3, 4, 5, 7};
    int w2_v  [2] = '{3, 4};
    int n2_v  [4] = '{2, 3, 4, 6};

    len_merge_top i_len_merge_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op1_wm(op1_wm), .op1_nm(op1_nm), .op1_esc(op1_esc),
        .op2_wm(op2_wm), .op2_nm(op2_nm), .mrm1(mrm1), .mrm2(mrm2),
        .out_valid(out_valid), .out_fallback(out_fallback), .out_len(out_len)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        op1_wm = '0; op1_nm = '0; op1_esc = 1'b0; op2_wm = '0;
        op2_nm = '0; mrm1 = '0; mrm2 = '0;
    endtask

    // Present current inputs with in_valid for one edge, sample after it
    task automatic apply_and_check(input int exp_len, input string req);
        logic [ML-1:0] ev;
        in_valid = 1'b1;
        @(negedge clk);
        ev = (exp_len > 0) ? (ML'(1) << (exp_len - 1)) : '0;
        chk(out_valid == 1'b1, req, "out_valid", 32'(out_valid), 1);
        chk(out_fallback == (exp_len == 0), req, "out_fallback",
            32'(out_fallback), 32'(exp_len == 0));
        chk(out_len == ev, req, "out_len", 32'(out_len), 32'(ev));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_fallback == 0 && out_len == '0, "R1",
            "reset outputs", {20'd0, out_valid, out_len}, 0);
        in_valid = 1'b1; op1_nm = 6'b000001;   // stimulus held during reset
        @(negedge clk);
        chk(out_valid == 0 && out_len == '0, "R1", "reset ignores input",
            {20'd0, out_valid, out_len}, 0);
        in_valid = 1'b0; clear_in();
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && out_fallback == 0 && out_len == '0, "R1",
            "first edge after reset", {20'd0, out_valid, out_len}, 0);
    endtask

    task automatic t_op1_plain();
        for (int i = 0; i < 6; i++) begin
            clear_in(); op1_nm[i] = 1'b1;
            apply_and_check(n1_v[i], "R3");
        end
    endtask

    task automatic t_op1_desc();
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 5; j++) begin
                clear_in(); op1_wm[i] = 1'b1; mrm1[j] = 1'b1;
                apply_and_check(w1_v[i] + add_v[j], "R4");
            end
    endtask

    task automatic t_escape();
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 5; j++) begin
                clear_in(); op1_esc = 1'b1; op2_wm[i] = 1'b1; mrm2[j] = 1'b1;
                apply_and_check(w2_v[i] + add_v[j], "R5");
            end
        for (int i = 0; i < 3; i++) begin
            clear_in(); op1_esc = 1'b1; op2_nm[i] = 1'b1;
            apply_and_check(n2_v[i], "R5");
        end
    endtask

    task automatic t_bypass();
        clear_in(); op1_esc = 1'b1; op2_nm[3] = 1'b1;
        apply_and_check(n2_v[3], "R6");
        // stray descriptor lines on the two-byte path do not disturb it
        clear_in(); op1_esc = 1'b1; op2_nm[3] = 1'b1; mrm2 = 5'b00100;
        apply_and_check(6, "R6");
    endtask

    task automatic t_gating();
        clear_in(); op1_nm[0] = 1'b1; op2_wm[1] = 1'b1; mrm2[4] = 1'b1; op2_nm = 4'b1001;
        apply_and_check(1, "R7");
        clear_in(); op1_nm[4] = 1'b1; mrm1[4] = 1'b1;
        apply_and_check(5, "R7");
        clear_in(); op1_nm[5] = 1'b1; op2_nm[3] = 1'b1;
        apply_and_check(7, "R7");
    endtask

    task automatic t_fallback();
        clear_in();
        apply_and_check(0, "R8");                 // no class at all
        clear_in(); op1_nm = 6'b010010;           // lengths 2 and 5
        apply_and_check(0, "R8");
        clear_in(); op1_esc = 1'b1;               // escape with no second class
        apply_and_check(0, "R8");
        clear_in(); op1_wm[3] = 1'b1;             // descriptor class, no addition
        apply_and_check(0, "R8");
        clear_in(); op1_wm[3] = 1'b1; mrm1 = 5'b11000; // lengths 10 and 11
        apply_and_check(0, "R8");
    endtask

    task automatic t_idle();
        clear_in(); op1_wm[3] = 1'b1; mrm1[4] = 1'b1;
        apply_and_check(11, "R2");
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 0 && out_fallback == 0 && out_len == '0, "R10",
            "idle clears", {19'd0, out_valid, out_fallback, out_len}, 0);
        clear_in();
        apply_and_check(0, "R2");
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_fallback == 0 && out_valid == 0, "R10", "idle clears fallback",
            {30'd0, out_valid, out_fallback}, 0);
        clear_in(); op1_nm[2] = 1'b1;
        apply_and_check(3, "R9");
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_op1_plain();
        t_op1_desc();
        t_escape();
        t_bypass();
        t_gating();
        t_fallback();
        t_idle();
        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule